// File: doc/BRIEF.md
# SMBus Control-Status Flag Logic

This block keeps the eight hardware-maintained flags of a two-wire serial bus controller's control register: bus master, transmit direction, start request, stop request, acknowledge-needed, received acknowledge, arbitration lost and the serial interrupt flag. A separate bit-level engine reports bus activity through single-cycle event strobes. The engine also supplies the sensed clock and data levels, plus the few qualifiers that the arbitration and acknowledge rules need. The block turns these events into flag updates with a fixed priority.

Software writes the register through a write strobe and a data word. A separate strobe marks each write to the data register, and the block uses it to decide the transmit direction of the next frame. The flags are visible on a parallel output at all times. An interrupt request is raised while the serial interrupt flag is high and the enable input is high. Software has to clear the serial interrupt flag itself, and clearing it also clears the arbitration-lost flag.

Register layout, used by the read and write paths alike: bit 0 serial interrupt, bit 1 ACK, bit 2 arbitration lost, bit 3 ACK requested, bit 4 stop, bit 5 start, bit 6 transmit mode, bit 7 master.

Top module: `smb_ctl_flags`

## Requirements
- R1: A synchronous active-low reset clears all eight flags, the pending data-written record and therefore the interrupt request.
- R2: The master flag (bit 7) is set by a generated START and cleared by a generated STOP or by arbitration loss. When set and clear arrive together, the clear wins.
- R3: A data-register write is remembered until the next frame-start strobe. At a frame start, transmit mode (bit 6) is set if such a write occurred, including one in the same cycle, and cleared if none did. A detected START or an arbitration loss clears it and wins over a set.
- R4: The start flag (bit 5) is set when an address byte following a START is received. The stop flag (bit 4) is set by a detected STOP while addressed as a slave or while master, and cleared by a generated STOP.
- R5: ACK requested (bit 3) is set when a received byte needs an acknowledge response and cleared at every acknowledge sample.
- R6: At an acknowledge sample, the ACK flag (bit 1) becomes 1 when the sensed data line is low and 0 when it is high.
- R7: Arbitration lost (bit 2) is set in three cases: a repeated START seen while master with bit 5 low; the clock line sensed low at a STOP or repeated-START check; or the data line sensed low while driving a 1 on a bit that is not an acknowledge bit.
- R8: Arbitration lost is cleared whenever software writes bit 0 as 0. Software writes to bits 2, 3, 6 and 7 are ignored.
- R9: The serial interrupt flag is set by a generated START, arbitration loss, a transmitted byte, a received byte, a received address or a detected STOP. Only a software write of 0 clears it.
- R10: When a software write and a hardware event hit the same flag in one cycle, the hardware set wins for bits 0 and 2 and the software value wins for bits 1, 4 and 5.
- R11: The interrupt request equals bit 0 AND the interrupt enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start_gen | input | 1 | Engine generated a START |
| ev_stop_gen | input | 1 | Engine generated a pending STOP |
| ev_start_det | input | 1 | START detected on the bus |
| ev_rstart_det | input | 1 | Repeated START detected on the bus |
| ev_stop_det | input | 1 | STOP detected on the bus |
| ev_frame_start | input | 1 | A new frame begins |
| ev_addr_rx | input | 1 | Address byte after a START received |
| ev_tx_done | input | 1 | Byte sent and its acknowledge received |
| ev_rx_done | input | 1 | Byte received |
| ev_ack_sample | input | 1 | Acknowledge bit sampled |
| ev_cond_chk | input | 1 | Clock check while generating STOP or repeated START |
| ev_bit_chk | input | 1 | Data check on a driven bit |
| scl_in | input | 1 | Sensed clock line level |
| sda_in | input | 1 | Sensed data line level |
| drv_bit | input | 1 | Value being driven on the current bit |
| bit_is_ack | input | 1 | Current checked bit is an acknowledge bit |
| rx_ack_needed | input | 1 | Received byte needs an acknowledge response |
| slv_addressed | input | 1 | Block is addressed as a slave |
| dat_wr | input | 1 | Data register written by software |
| sw_wr | input | 1 | Software write to the flag register |
| sw_wdata | input | 8 | Software write data |
| irq_en | input | 1 | Interrupt enable |
| flags | output | 8 | Current flag values |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each event strobe lasts one cycle and that the engine raises a START or STOP generation event only while it is actually driving that condition. The acknowledge-follow check also assumes that software does not write the register in the same cycle as an acknowledge sample. Simultaneous strobes are taken to be ones the bus can produce, such as a START generated together with a frame start. The stimulus changes inputs only away from the clock edge, pairs strobes only in those legal combinations, and keeps a software write aside from an acknowledge sample except in the one vector that tests write priority.

// File: rtl/smb_flag_pkg.sv
`timescale 1ns/1ps
package smb_flag_pkg;

   localparam int unsigned FLAG_W = 8;

   // bit positions of the flag register
   localparam int unsigned F_SI    = 0;
   localparam int unsigned F_ACK   = 1;
   localparam int unsigned F_ARB   = 2;
   localparam int unsigned F_ACKRQ = 3;
   localparam int unsigned F_STO   = 4;
   localparam int unsigned F_STA   = 5;
   localparam int unsigned F_TX    = 6;
   localparam int unsigned F_MST   = 7;

   localparam int unsigned ARB_CAUSES = 3;

   // update priority of a single flag cell
   typedef enum logic {
      PRIO_SW_FIRST = 1'b0,
      PRIO_HW_FIRST = 1'b1
   } prio_e;

endpackage

// File: rtl/smb_flag_cell.sv
`timescale 1ns/1ps
module smb_flag_cell
   import smb_flag_pkg::*;
#(
   parameter prio_e PRIO        = PRIO_SW_FIRST,
   parameter bit    SW_WRITABLE = 1'b1,
   parameter bit    RST_VAL     = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic hw_clr,
   input  logic sw_wr,
   input  logic sw_val,
   output logic q
);

   logic sw_en;
   logic nxt;

   assign sw_en = sw_wr & SW_WRITABLE;

   generate
      if (PRIO == PRIO_HW_FIRST) begin : g_hw_first
         // hardware set, then hardware clear, then software, then hold
         always_comb begin
            if (hw_set)      nxt = 1'b1;
            else if (hw_clr) nxt = 1'b0;
            else if (sw_en)  nxt = sw_val;
            else             nxt = q;
         end

         AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set |=> q); // R10
      end else begin : g_sw_first
         // software, then hardware clear, then hardware set, then hold
         always_comb begin
            if (sw_en)       nxt = sw_val;
            else if (hw_clr) nxt = 1'b0;
            else if (hw_set) nxt = 1'b1;
            else             nxt = q;
         end

         AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            sw_en |=> (q == $past(sw_val))); // R10
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end

endmodule

// File: rtl/smb_arb_detect.sv
`timescale 1ns/1ps
module smb_arb_detect
   import smb_flag_pkg::*;
#(
   parameter bit ACK_BIT_EXEMPT = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic ev_rstart_det,
   input  logic mst_q,
   input  logic sta_q,
   input  logic ev_cond_chk,
   input  logic scl_in,
   input  logic ev_bit_chk,
   input  logic drv_bit,
   input  logic bit_is_ack,
   input  logic sda_in,
   output logic arb_evt
);

   logic [ARB_CAUSES-1:0] cause;
   logic                  bit_counts;

   generate
      if (ACK_BIT_EXEMPT) begin : g_ack_exempt
         assign bit_counts = ~bit_is_ack;
      end else begin : g_ack_checked
         logic unused_ack;
         assign unused_ack = bit_is_ack;
         assign bit_counts = 1'b1;
      end
   endgenerate

   // cause 0: unexpected repeated START while master
   assign cause[0] = ev_rstart_det & mst_q & ~sta_q;
   // cause 1: clock held low while forming STOP or repeated START
   assign cause[1] = ev_cond_chk & ~scl_in;
   // cause 2: data pulled low while a 1 is driven
   assign cause[2] = ev_bit_chk & drv_bit & ~sda_in & bit_counts;

   assign arb_evt = |cause;

   AST_ARB_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      arb_evt |-> (ev_rstart_det | ev_cond_chk | ev_bit_chk)); // R7

endmodule

// File: rtl/smb_event_map.sv
`timescale 1ns/1ps
module smb_event_map
   import smb_flag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start_gen,
   input  logic              ev_stop_gen,
   input  logic              ev_start_det,
   input  logic              ev_stop_det,
   input  logic              ev_frame_start,
   input  logic              ev_addr_rx,
   input  logic              ev_tx_done,
   input  logic              ev_rx_done,
   input  logic              ev_ack_sample,
   input  logic              sda_in,
   input  logic              rx_ack_needed,
   input  logic              slv_addressed,
   input  logic              dat_wr,
   input  logic              sw_wr,
   input  logic              sw_si_val,
   input  logic              mst_q,
   input  logic              arb_evt,
   output logic [FLAG_W-1:0] set_v,
   output logic [FLAG_W-1:0] clr_v
);

   logic txpend_q;
   logic pend_eff;
   logic si_sw_clr;

   // a write in the frame-start cycle still counts for that frame
   assign pend_eff  = txpend_q | dat_wr;
   assign si_sw_clr = sw_wr & ~sw_si_val;

   always_ff @(posedge clk) begin
      if (!rst_n)              txpend_q <= 1'b0;
      else if (ev_frame_start) txpend_q <= 1'b0;
      else if (dat_wr)         txpend_q <= 1'b1;
   end

   always_comb begin
      set_v = '0;
      clr_v = '0;

      set_v[F_MST]   = ev_start_gen;
      clr_v[F_MST]   = ev_stop_gen | arb_evt;

      set_v[F_TX]    = ev_frame_start & pend_eff;
      clr_v[F_TX]    = ev_start_det | arb_evt | (ev_frame_start & ~pend_eff);

      set_v[F_STA]   = ev_addr_rx;

      set_v[F_STO]   = ev_stop_det & (slv_addressed | mst_q);
      clr_v[F_STO]   = ev_stop_gen;

      set_v[F_ACKRQ] = ev_rx_done & rx_ack_needed;
      clr_v[F_ACKRQ] = ev_ack_sample;

      set_v[F_ACK]   = ev_ack_sample & ~sda_in;
      clr_v[F_ACK]   = ev_ack_sample & sda_in;

      set_v[F_ARB]   = arb_evt;
      clr_v[F_ARB]   = si_sw_clr;

      set_v[F_SI]    = ev_start_gen | arb_evt | ev_tx_done | ev_rx_done
                     | ev_addr_rx | ev_stop_det;
   end

   AST_TXPEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      ev_frame_start |=> !txpend_q); // R3

   AST_TXPEND_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr && !ev_frame_start |=> txpend_q); // R3

endmodule

// File: rtl/smb_ctl_flags.sv
`timescale 1ns/1ps
module smb_ctl_flags
   import smb_flag_pkg::*;
#(
   parameter logic [FLAG_W-1:0] HW_FIRST_MASK  = 8'h05,
   parameter logic [FLAG_W-1:0] SW_WR_MASK     = 8'h33,
   parameter logic [FLAG_W-1:0] RST_VAL        = 8'h00,
   parameter bit                ACK_BIT_EXEMPT = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start_gen,
   input  logic              ev_stop_gen,
   input  logic              ev_start_det,
   input  logic              ev_rstart_det,
   input  logic              ev_stop_det,
   input  logic              ev_frame_start,
   input  logic              ev_addr_rx,
   input  logic              ev_tx_done,
   input  logic              ev_rx_done,
   input  logic              ev_ack_sample,
   input  logic              ev_cond_chk,
   input  logic              ev_bit_chk,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              drv_bit,
   input  logic              bit_is_ack,
   input  logic              rx_ack_needed,
   input  logic              slv_addressed,
   input  logic              dat_wr,
   input  logic              sw_wr,
   input  logic [FLAG_W-1:0] sw_wdata,
   input  logic              irq_en,
   output logic [FLAG_W-1:0] flags,
   output logic              irq
);

   // elaboration-time configuration checks
   generate
      if (SW_WR_MASK[F_ARB] != 1'b0) begin : g_bad_arb_wr
         initial $fatal(1, "arbitration flag must not be software writable");
      end
      if (HW_FIRST_MASK[F_SI] != 1'b1 || HW_FIRST_MASK[F_ARB] != 1'b1) begin : g_bad_prio
         initial $fatal(1, "interrupt and arbitration flags need hardware priority");
      end
      if (SW_WR_MASK[F_SI] != 1'b1) begin : g_bad_si_wr
         initial $fatal(1, "interrupt flag must be software clearable");
      end
   endgenerate

   logic [FLAG_W-1:0] set_v;
   logic [FLAG_W-1:0] clr_v;
   logic [FLAG_W-1:0] flags_q;
   logic              arb_evt;

   smb_arb_detect #(
      .ACK_BIT_EXEMPT (ACK_BIT_EXEMPT)
   ) u_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .ev_rstart_det (ev_rstart_det),
      .mst_q         (flags_q[F_MST]),
      .sta_q         (flags_q[F_STA]),
      .ev_cond_chk   (ev_cond_chk),
      .scl_in        (scl_in),
      .ev_bit_chk    (ev_bit_chk),
      .drv_bit       (drv_bit),
      .bit_is_ack    (bit_is_ack),
      .sda_in        (sda_in),
      .arb_evt       (arb_evt)
   );

   smb_event_map u_map (
      .clk            (clk),
      .rst_n          (rst_n),
      .ev_start_gen   (ev_start_gen),
      .ev_stop_gen    (ev_stop_gen),
      .ev_start_det   (ev_start_det),
      .ev_stop_det    (ev_stop_det),
      .ev_frame_start (ev_frame_start),
      .ev_addr_rx     (ev_addr_rx),
      .ev_tx_done     (ev_tx_done),
      .ev_rx_done     (ev_rx_done),
      .ev_ack_sample  (ev_ack_sample),
      .sda_in         (sda_in),
      .rx_ack_needed  (rx_ack_needed),
      .slv_addressed  (slv_addressed),
      .dat_wr         (dat_wr),
      .sw_wr          (sw_wr),
      .sw_si_val      (sw_wdata[F_SI]),
      .mst_q          (flags_q[F_MST]),
      .arb_evt        (arb_evt),
      .set_v          (set_v),
      .clr_v          (clr_v)
   );

   generate
      for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
         smb_flag_cell #(
            .PRIO        (HW_FIRST_MASK[i] ? PRIO_HW_FIRST : PRIO_SW_FIRST),
            .SW_WRITABLE (SW_WR_MASK[i]),
            .RST_VAL     (RST_VAL[i])
         ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (set_v[i]),
            .hw_clr (clr_v[i]),
            .sw_wr  (sw_wr),
            .sw_val (sw_wdata[i]),
            .q      (flags_q[i])
         );
      end
   endgenerate

   assign flags = flags_q;
   assign irq   = flags_q[F_SI] & irq_en;

   AST_RST_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (flags == RST_VAL)); // R1

   AST_MST_DROPS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop_gen |=> !flags[F_MST]); // R2

   AST_ACK_TRACKS_SDA: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ack_sample && !sw_wr |=> (flags[F_ACK] == !$past(sda_in))); // R6

   AST_ARB_CLR_WITH_SI: assert property (@(posedge clk) disable iff (!rst_n)
      flags[F_ARB] && sw_wr && !sw_wdata[F_SI] && !arb_evt |=> !flags[F_ARB]); // R8

   AST_SI_NO_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      flags[F_SI] && !(sw_wr && !sw_wdata[F_SI]) |=> flags[F_SI]); // R9

   AST_ARB_RAISES_SI: assert property (@(posedge clk) disable iff (!rst_n)
      arb_evt |=> (flags[F_SI] && flags[F_ARB] && !flags[F_MST])); // R7

endmodule

// File: tb/smb_ctl_flags_tb_top.sv
`timescale 1ns/1ps
module smb_ctl_flags_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [11:0] ev;
   logic [5:0]  lv;
   logic       dat_wr, sw_wr, irq_en;
   logic [7:0] sw_wdata;
   logic [7:0] flags;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   smb_ctl_flags dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .ev_start_gen   (ev[11]),
      .ev_stop_gen    (ev[10]),
      .ev_start_det   (ev[9]),
      .ev_rstart_det  (ev[8]),
      .ev_stop_det    (ev[7]),
      .ev_frame_start (ev[6]),
      .ev_addr_rx     (ev[5]),
      .ev_tx_done     (ev[4]),
      .ev_rx_done     (ev[3]),
      .ev_ack_sample  (ev[2]),
      .ev_cond_chk    (ev[1]),
      .ev_bit_chk     (ev[0]),
      .scl_in         (lv[5]),
      .sda_in         (lv[4]),
      .drv_bit        (lv[3]),
      .bit_is_ack     (lv[2]),
      .rx_ack_needed  (lv[1]),
      .slv_addressed  (lv[0]),
      .dat_wr         (dat_wr),
      .sw_wr          (sw_wr),
      .sw_wdata       (sw_wdata),
      .irq_en         (irq_en),
      .flags          (flags),
      .irq            (irq)
   );

   // event strobes
   localparam logic [11:0] E_NO = 12'h000;
   localparam logic [11:0] E_SG = 12'h800;
   localparam logic [11:0] E_PG = 12'h400;
   localparam logic [11:0] E_SD = 12'h200;
   localparam logic [11:0] E_RS = 12'h100;
   localparam logic [11:0] E_PD = 12'h080;
   localparam logic [11:0] E_FS = 12'h040;
   localparam logic [11:0] E_AR = 12'h020;
   localparam logic [11:0] E_TX = 12'h010;
   localparam logic [11:0] E_RX = 12'h008;
   localparam logic [11:0] E_AK = 12'h004;
   localparam logic [11:0] E_CC = 12'h002;
   localparam logic [11:0] E_BC = 12'h001;
   // levels {scl, sda, drv, is_ack, rx_need, slave}
   localparam logic [5:0] L_IDLE = 6'b110000;
   localparam logic [5:0] L_ARB  = 6'b101000;
   localparam logic [5:0] L_ACKB = 6'b101100;
   localparam logic [5:0] L_RXN  = 6'b110010;
   localparam logic [5:0] L_SDA0 = 6'b100000;
   localparam logic [5:0] L_SLV  = 6'b110001;
   localparam logic [5:0] L_SCL0 = 6'b010000;

   // {req, events, levels, sw_wr, wdata, dat_wr, expected flags}
   localparam int NV = 31;
   localparam logic [39:0] TBL [NV] = '{
      {4'd10, E_NO,      L_IDLE, 1'b1, 8'h20, 1'b0, 8'h20}, // R10 start bit writable
      {4'd3,  E_NO,      L_IDLE, 1'b0, 8'h00, 1'b1, 8'h20}, // R3 data written
      {4'd2,  E_SG|E_FS, L_IDLE, 1'b0, 8'h00, 1'b0, 8'hE1}, // R2 R3 R9
      {4'd9,  E_NO,      L_IDLE, 1'b1, 8'h00, 1'b0, 8'hC0}, // R9 software clears
      {4'd7,  E_BC,      L_ARB,  1'b0, 8'h00, 1'b0, 8'h05}, // R7 data low on 1
      {4'd8,  E_NO,      L_IDLE, 1'b1, 8'h00, 1'b0, 8'h00}, // R8
      {4'd4,  E_AR,      L_IDLE, 1'b0, 8'h00, 1'b0, 8'h21}, // R4 address received
      {4'd5,  E_RX,      L_RXN,  1'b0, 8'h00, 1'b0, 8'h29}, // R5
      {4'd6,  E_AK,      L_SDA0, 1'b0, 8'h00, 1'b0, 8'h23}, // R6 R5
      {4'd4,  E_PD,      L_SLV,  1'b0, 8'h00, 1'b0, 8'h33}, // R4 stop as slave
      {4'd10, E_TX,      L_IDLE, 1'b1, 8'h00, 1'b0, 8'h01}, // R10 SI set wins
      {4'd10, E_AK,      L_IDLE, 1'b1, 8'h02, 1'b0, 8'h02}, // R10 software ACK wins
      {4'd7,  E_BC,      L_ACKB, 1'b0, 8'h00, 1'b0, 8'h02}, // R7 ack bit exempt
      {4'd12, E_SG,      L_IDLE, 1'b0, 8'h00, 1'b0, 8'h83}, // layout check, R2
      {4'd7,  E_RS,      L_IDLE, 1'b0, 8'h00, 1'b0, 8'h07}, // R7 repeated START
      {4'd8,  E_NO,      L_IDLE, 1'b1, 8'h20, 1'b0, 8'h20}, // R8
      {4'd2,  E_SG,      L_IDLE, 1'b0, 8'h00, 1'b0, 8'hA1}, // R2
      {4'd7,  E_RS,      L_IDLE, 1'b0, 8'h00, 1'b0, 8'hA1}, // R7 start bit high
      {4'd7,  E_CC,      L_SCL0, 1'b0, 8'h00, 1'b0, 8'h25}, // R7 clock low
      {4'd10, E_BC,      L_ARB,  1'b1, 8'h00, 1'b0, 8'h05}, // R10 arb wins
      {4'd8,  E_NO,      L_IDLE, 1'b1, 8'h00, 1'b0, 8'h00}, // R8
      {4'd3,  E_NO,      L_IDLE, 1'b0, 8'h00, 1'b1, 8'h00}, // R3
      {4'd3,  E_FS,      L_IDLE, 1'b0, 8'h00, 1'b0, 8'h40}, // R3
      {4'd3,  E_FS,      L_IDLE, 1'b0, 8'h00, 1'b0, 8'h00}, // R3 no write
      {4'd3,  E_SG,      L_IDLE, 1'b0, 8'h00, 1'b1, 8'h81}, // R3 R2
      {4'd3,  E_SD|E_FS, L_IDLE, 1'b0, 8'h00, 1'b0, 8'h81}, // R3 clear wins
      {4'd4,  E_NO,      L_IDLE, 1'b1, 8'h10, 1'b0, 8'h90}, // R4
      {4'd4,  E_PG,      L_IDLE, 1'b0, 8'h00, 1'b0, 8'h00}, // R4 R2
      {4'd2,  E_SG|E_PG, L_IDLE, 1'b0, 8'h00, 1'b0, 8'h01}, // R2 clear wins
      {4'd2,  E_SG,      L_IDLE, 1'b0, 8'h00, 1'b0, 8'h81}, // R2
      {4'd4,  E_PD,      L_IDLE, 1'b0, 8'h00, 1'b0, 8'h91}  // R4 stop as master
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ev = E_NO; lv = L_IDLE; dat_wr = 1'b0; sw_wr = 1'b0; sw_wdata = 8'h00;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; irq_en = 1'b1;
      idle_inputs();
      repeat (4) @(negedge clk);
      chk("R1 reset flags", flags, 8'h00);
      chk("R1 reset irq", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         ev = TBL[i][35:24]; lv = TBL[i][23:18];
         sw_wr = TBL[i][17]; sw_wdata = TBL[i][16:9]; dat_wr = TBL[i][8];
         step();
         idle_inputs();
         checks++;
         if (flags !== TBL[i][7:0] || irq !== TBL[i][0]) begin
            errors++;
            $display("FAIL R%0d vector %0d: actual %h/%b expected %h/%b",
                     TBL[i][39:36], i, flags, irq, TBL[i][7:0], TBL[i][0]);
         end
      end

      // R11: interrupt gating, SI is high here
      irq_en = 1'b0; #1;
      chk("R11 irq masked", {7'd0, irq}, 8'h00);
      irq_en = 1'b1; #1;
      chk("R11 irq enabled", {7'd0, irq}, 8'h01);

      // R1: reset with flags set and a write in flight
      rst_n = 1'b0; sw_wr = 1'b1; sw_wdata = 8'hFF;
      step();
      idle_inputs();
      chk("R1 reset mid-run", flags, 8'h00);
      rst_n = 1'b1;

      // R1 R3: reset drops a remembered data write
      dat_wr = 1'b1; step(); idle_inputs();
      rst_n = 1'b0; step(); rst_n = 1'b1;
      ev = E_FS; step(); idle_inputs();
      chk("R3 pending cleared by reset", flags, 8'h00);

      // R8: software cannot touch read-only bits 2, 3, 6, 7
      sw_wr = 1'b1; sw_wdata = 8'hCC; step(); idle_inputs();
      chk("R8 read-only bits ignored", flags, 8'h00);

      // R6: sample with high data line clears a set ACK
      sw_wr = 1'b1; sw_wdata = 8'h02; step(); idle_inputs();
      ev = E_AK; step(); idle_inputs();
      chk("R6 nack clears ack", flags, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule